// File: doc/BRIEF.md
# Mode-Aware GPIO Port Register Block

This block holds the control state for one general-purpose I/O port that is eight bits wide on the register bus but has only four usable pins. It keeps three registers: a direction register, an output data register and a pull-up control register. A CPU reaches them through a simple register bus with an address, a write strobe, a read strobe and 8-bit data. The block drives each pin's output enable, output value and pull-up enable, and it samples the pin levels through a synchroniser.

A 3-bit operating-mode input splits the modes into two groups. In the open group (modes 0 to 4), the direction register resets to all ones, reads back its stored value, and pull-ups stay off. In the restricted group (modes 5 to 7), the direction register resets to 0xF0, cannot be read (every read returns 0xFF), and a pin gets its pull-up only when it is an input and its pull-up bit is set. Reset and hardware standby load the initial values. Software standby freezes all three registers, so a pin that is driving keeps driving its stored level.

Top module: `mode_gpio_port`

## Requirements
- R1: On a clock edge with `rst_n` low or `hw_stby` high, the direction register loads 0xFF when `mode` is 0 to 4 and 0xF0 when `mode` is 5 to 7.
- R2: A read of address 0 (direction) returns the stored 8-bit direction value when `mode` is 0 to 4, and 0xFF when `mode` is 5 to 7.
- R3: The data register (address 1) and the pull-up register (address 2) initialise to 0xF0. Bits 7 to 4 of both always read 1 and ignore writes. Bits 3 to 0 are read/write.
- R4: A read of address 1 returns, for each pin n in 3..0, data bit n when direction bit n is 1 and the synchronised pin level when direction bit n is 0.
- R5: A pin level change appears on the address 1 read path after exactly two rising clock edges, and not after one.
- R6: `pin_oe[n]` equals direction bit n and `pin_out[n]` equals data bit n, for n in 3..0. Direction bits 7 to 4 are stored but drive no pin.
- R7: `pin_pu[n]` is 1 only when `mode` is 5 to 7, direction bit n is 0 and pull-up bit n is 1. In modes 0 to 4, `pin_pu` is 0.
- R8: While `sw_stby` is high (and `hw_stby` is low), all three registers hold their values and writes are ignored.
- R9: A write with `wr_en` high takes effect on that rising clock edge. Reads are combinational. `rd_data` is 0x00 when `rd_en` is low, and 0xFF for address 3.
- R10: `hw_stby` takes priority over a write in the same cycle: the data register goes to 0xF0 and the pull-up register goes to 0xF0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hw_stby | input | 1 | Hardware standby; initialises the registers |
| sw_stby | input | 1 | Software standby; freezes the registers |
| mode | input | 3 | Operating mode; 5 to 7 select the restricted group |
| addr | input | 2 | Register address: 0 direction, 1 data/port, 2 pull-up |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, combinational |
| pin_in | input | 4 | Asynchronous pin levels |
| pin_oe | output | 4 | Pin output enables |
| pin_out | output | 4 | Pin output values |
| pin_pu | output | 4 | Pin pull-up enables |

## Verification
The assertions assume that `mode` is steady around each reset or hardware-standby edge, because the direction initial value is taken from the mode sampled at that edge. They also assume that `rst_n` stays low for at least two edges, so the synchroniser stage relations start from known values. The stimulus changes `mode` only while reset is held, holds reset for several cycles, and drives every bus and pin input at the falling clock edge. Each strobe therefore stays stable across the rising edge that samples it.

// File: rtl/mode_gpio_pkg.sv
package mode_gpio_pkg;

   typedef enum logic [1:0] {
      SEL_DIR  = 2'd0,
      SEL_DATA = 2'd1,
      SEL_PULL = 2'd2,
      SEL_NONE = 2'd3
   } reg_sel_e;

   function automatic logic in_restricted_group(input int mode_val, input int first_restricted);
      return mode_val >= first_restricted;
   endfunction

endpackage

// File: rtl/mgp_sync.sv
module mgp_sync #(
   parameter int WIDTH  = 4,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("mgp_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stg [STAGES];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= '0;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];

   for (genvar s = 1; s < STAGES; s++) begin : g_stage_chk
      // R5
      sync_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
         rst_n |=> stg[s] == $past(stg[s-1]));
   end

endmodule

// File: rtl/mgp_regs.sv
module mgp_regs
   import mode_gpio_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int PIN_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hw_stby,
   input  logic              sw_stby,
   input  logic              restricted,
   input  logic              wr_en,
   input  reg_sel_e          wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] dir_q,
   output logic [PIN_W-1:0]  dat_q,
   output logic [PIN_W-1:0]  pul_q
);

   localparam logic [DATA_W-1:0] DIR_INIT_OPEN = '1;
   localparam logic [DATA_W-1:0] DIR_INIT_RSTR = {{(DATA_W-PIN_W){1'b1}}, {PIN_W{1'b0}}};

   logic init_now;
   logic wr_ok;

   assign init_now = !rst_n || hw_stby;
   assign wr_ok    = wr_en && !sw_stby;

   always_ff @(posedge clk) begin
      if (init_now) begin
         dir_q <= restricted ? DIR_INIT_RSTR : DIR_INIT_OPEN;
         dat_q <= '0;
         pul_q <= '0;
      end else if (wr_ok) begin
         case (wr_sel)
            SEL_DIR:  dir_q <= wr_data;
            SEL_DATA: dat_q <= wr_data[PIN_W-1:0];
            SEL_PULL: pul_q <= wr_data[PIN_W-1:0];
            default:  ;
         endcase
      end
   end

   // R1
   dir_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hw_stby |=> dir_q == ($past(restricted) ? DIR_INIT_RSTR : DIR_INIT_OPEN));

   // R10
   stby_over_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hw_stby |=> (dat_q == '0) && (pul_q == '0));

   // R8
   sw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_stby && !hw_stby) |=> $stable(dir_q) && $stable(dat_q) && $stable(pul_q));

endmodule

// File: rtl/mgp_pins.sv
module mgp_pins #(
   parameter int PIN_W     = 4,
   parameter bit PULLUP_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restricted,
   input  logic [PIN_W-1:0] dir_lo,
   input  logic [PIN_W-1:0] dat,
   input  logic [PIN_W-1:0] pul,
   output logic [PIN_W-1:0] pin_oe,
   output logic [PIN_W-1:0] pin_out,
   output logic [PIN_W-1:0] pin_pu
);

   assign pin_oe  = dir_lo;
   assign pin_out = dat;

   if (PULLUP_EN) begin : g_pull
      for (genvar n = 0; n < PIN_W; n++) begin : g_bit
         assign pin_pu[n] = restricted && !dir_lo[n] && pul[n];
      end
   end else begin : g_no_pull
      assign pin_pu = '0;
      logic unused_pull;
      assign unused_pull = ^pul;
   end

   // R7
   pu_open_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !restricted |-> pin_pu == '0);

   // R7
   pu_driver_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_pu & pin_oe) == '0);

endmodule

// File: rtl/mode_gpio_port.sv
module mode_gpio_port
   import mode_gpio_pkg::*;
#(
   parameter int DATA_W          = 8,
   parameter int PIN_W           = 4,
   parameter int MODE_W          = 3,
   parameter int FIRST_RESTRICT  = 5,
   parameter int SYNC_STAGES     = 2,
   parameter bit PULLUP_EN       = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hw_stby,
   input  logic              sw_stby,
   input  logic [MODE_W-1:0] mode,
   input  logic [1:0]        addr,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   input  logic [PIN_W-1:0]  pin_in,
   output logic [PIN_W-1:0]  pin_oe,
   output logic [PIN_W-1:0]  pin_out,
   output logic [PIN_W-1:0]  pin_pu
);

   localparam int FIXED_W = DATA_W - PIN_W;
   localparam logic [FIXED_W-1:0] FIXED_ONES = '1;

   if (PIN_W < 1 || PIN_W >= DATA_W) begin : g_bad_pin_w
      $error("mode_gpio_port: PIN_W must be between 1 and DATA_W-1");
   end
   if (FIRST_RESTRICT < 0 || FIRST_RESTRICT > (1 << MODE_W)) begin : g_bad_first
      $error("mode_gpio_port: FIRST_RESTRICT out of mode range");
   end

   logic              restricted;
   reg_sel_e          sel;
   logic [DATA_W-1:0] dir_q;
   logic [PIN_W-1:0]  dat_q;
   logic [PIN_W-1:0]  pul_q;
   logic [PIN_W-1:0]  pin_s;
   logic [PIN_W-1:0]  port_lo;

   assign restricted = in_restricted_group(int'(mode), FIRST_RESTRICT);
   assign sel        = reg_sel_e'(addr);

   mgp_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (pin_s)
   );

   mgp_regs #(.DATA_W(DATA_W), .PIN_W(PIN_W)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .hw_stby    (hw_stby),
      .sw_stby    (sw_stby),
      .restricted (restricted),
      .wr_en      (wr_en),
      .wr_sel     (sel),
      .wr_data    (wr_data),
      .dir_q      (dir_q),
      .dat_q      (dat_q),
      .pul_q      (pul_q)
   );

   mgp_pins #(.PIN_W(PIN_W), .PULLUP_EN(PULLUP_EN)) u_pins (
      .clk        (clk),
      .rst_n      (rst_n),
      .restricted (restricted),
      .dir_lo     (dir_q[PIN_W-1:0]),
      .dat        (dat_q),
      .pul        (pul_q),
      .pin_oe     (pin_oe),
      .pin_out    (pin_out),
      .pin_pu     (pin_pu)
   );

   for (genvar n = 0; n < PIN_W; n++) begin : g_port_mix
      assign port_lo[n] = dir_q[n] ? dat_q[n] : pin_s[n];
   end

   always_comb begin
      rd_data = '0;
      if (rd_en) begin
         case (sel)
            SEL_DIR:  rd_data = restricted ? '1 : dir_q;
            SEL_DATA: rd_data = {FIXED_ONES, port_lo};
            SEL_PULL: rd_data = {FIXED_ONES, pul_q};
            default:  rd_data = '1;
         endcase
      end
   end

   // R2
   dir_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && sel == SEL_DIR && restricted) |-> rd_data == '1);

   // R3
   fixed_nibble_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && (sel == SEL_DATA || sel == SEL_PULL)) |-> rd_data[DATA_W-1:PIN_W] == FIXED_ONES);

   // R6
   oe_follows_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && sel == SEL_DIR && !sw_stby && !hw_stby) |=> pin_oe == $past(wr_data[PIN_W-1:0]));

   // R9
   idle_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |-> rd_data == '0);

endmodule

// File: tb/mode_gpio_port_bench.sv
module mode_gpio_port_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       hw_stby = 1'b0;
   logic       sw_stby = 1'b0;
   logic [2:0] mode = 3'd0;
   logic [1:0] addr = 2'd0;
   logic       wr_en = 1'b0;
   logic       rd_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic [7:0] rd_data;
   logic [3:0] pin_in = 4'h0;
   logic [3:0] pin_oe, pin_out, pin_pu;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   mode_gpio_port u_mode_gpio_port (
      .clk(clk), .rst_n(rst_n), .hw_stby(hw_stby), .sw_stby(sw_stby),
      .mode(mode), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
      .wr_data(wr_data), .rd_data(rd_data), .pin_in(pin_in),
      .pin_oe(pin_oe), .pin_out(pin_out), .pin_pu(pin_pu)
   );

   // mode, dir, dat, pcr, pins, exp port read, exp dir read, exp pcr read, exp pu, exp oe, exp out
   localparam logic [67:0] VEC [7] = '{
      68'h20F050FAF50FFF0F5,
      68'h6030F0C5F7FFFCC3F,
      68'h5000A059F9FFF550A,
      68'h7F8000FFF7FFFF780,
      68'h1303CF36F630F300C,
      68'h4A5FF000F5A5F005F,
      68'h000000F3F300FF000
   };

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_reset(input logic [2:0] m);
      @(negedge clk);
      rst_n = 1'b0;
      mode  = m;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      addr = a; wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      addr = a; rd_en = 1'b1;
      #1 d = rd_data;
      rd_en = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;

      // Reset state, open mode
      do_reset(3'd2);
      rd(2'd0, v); chk("R1 dir init open", v, 8'hFF);
      rd(2'd1, v); chk("R3 data init", v, 8'hF0);
      rd(2'd2, v); chk("R3 pull init", v, 8'hF0);
      chk("R6 oe after reset open", {4'h0, pin_oe}, 8'h0F);
      chk("R6 out after reset", {4'h0, pin_out}, 8'h00);
      rd(2'd3, v); chk("R9 unmapped", v, 8'hFF);
      @(negedge clk); #1 chk("R9 idle read", rd_data, 8'h00);

      // Reset state, restricted mode
      do_reset(3'd6);
      rd(2'd0, v); chk("R2 dir hidden", v, 8'hFF);
      chk("R1 dir init restricted", {4'h0, pin_oe}, 8'h00);
      chk("R7 pu after reset", {4'h0, pin_pu}, 8'h00);

      // Vector table
      for (int i = 0; i < 7; i++) begin
         logic [67:0] e;
         e = VEC[i];
         do_reset(e[67:64]);
         wr(2'd0, e[63:56]);
         wr(2'd1, e[55:48]);
         wr(2'd2, e[47:40]);
         pin_in = e[39:36];
         repeat (3) @(negedge clk);
         rd(2'd1, v); chk("R4 port read", v, e[35:28]);
         rd(2'd0, v); chk("R2 dir read", v, e[27:20]);
         rd(2'd2, v); chk("R3 pull read", v, e[19:12]);
         chk("R7 pull enable", {4'h0, pin_pu}, {4'h0, e[11:8]});
         chk("R6 output enable", {4'h0, pin_oe}, {4'h0, e[7:4]});
         chk("R6 output value", {4'h0, pin_out}, {4'h0, e[3:0]});
      end

      // R5 synchroniser latency
      do_reset(3'd6);
      pin_in = 4'h0;
      repeat (3) @(negedge clk);
      pin_in = 4'hA;
      @(posedge clk); #1;
      rd_en = 1'b1; addr = 2'd1; #1 chk("R5 one edge", rd_data, 8'hF0);
      @(posedge clk); #1 chk("R5 two edges", rd_data, 8'hFA);
      rd_en = 1'b0;

      // R9 write timing
      @(negedge clk);
      addr = 2'd1; wr_data = 8'h09; wr_en = 1'b1;
      #1 chk("R9 before edge", {4'h0, pin_out}, 8'h00);
      @(posedge clk); #1 chk("R9 at edge", {4'h0, pin_out}, 8'h09);
      @(negedge clk); wr_en = 1'b0;

      // R8 software standby
      wr(2'd0, 8'h0F);
      wr(2'd1, 8'h05);
      @(negedge clk); sw_stby = 1'b1;
      wr(2'd1, 8'h0A);
      wr(2'd0, 8'h00);
      wr(2'd2, 8'h0F);
      chk("R8 out held", {4'h0, pin_out}, 8'h05);
      chk("R8 oe held", {4'h0, pin_oe}, 8'h0F);
      rd(2'd2, v); chk("R8 pull held", v, 8'hF0);
      @(negedge clk); sw_stby = 1'b0;

      // R10 hardware standby beats a write
      wr(2'd2, 8'h03);
      @(negedge clk);
      hw_stby = 1'b1; addr = 2'd1; wr_data = 8'h0F; wr_en = 1'b1;
      @(negedge clk);
      hw_stby = 1'b0; wr_en = 1'b0;
      chk("R10 out init", {4'h0, pin_out}, 8'h00);
      chk("R10 oe init", {4'h0, pin_oe}, 8'h00);
      rd(2'd2, v); chk("R10 pull init", v, 8'hF0);

      // R1 hardware standby in open mode
      do_reset(3'd3);
      wr(2'd0, 8'h00);
      @(negedge clk); hw_stby = 1'b1;
      @(negedge clk); hw_stby = 1'b0;
      rd(2'd0, v); chk("R1 hw standby open", v, 8'hFF);

      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule